// File: doc/BRIEF.md
# Accumulator Processor with Index Register

This block is a small multicycle processor built around one 16-bit accumulator, one index register and a program counter. Code and data share a single word-addressed memory. The processor reaches that memory through a synchronous port: a read returns its data one cycle after the request. The instruction set covers memory load and store, add and subtract, arithmetic shifts by one, jumps, and a conditional branch on the accumulator sign.

Two further groups of instructions cover array loops. The first group reads or rewrites only the address field of a word, so a program can step through an array by patching its own instructions. The second group manages the index register, which any memory-referencing instruction can add to its address field. A combined test-and-step branch closes an indexed loop.

A debug view shows the program counter, the accumulator and the index register. A halt output reports that the processor has stopped.

Top module: `accum_cpu`

## Requirements
- R1: While reset is high and in the first cycle after it, PC, AC and IX read zero and `halted` is low; execution then starts with a fetch from address 0.
- R2: An instruction word holds the opcode in bits 15:12, the index-enable flag in bit 11 and the address field in bits 10:0. When the flag is set, the effective address is the address field plus IX, taken modulo 2048; otherwise it is the address field. Opcodes: 0 HALT, 1 LOAD, 2 STORE, 3 ADD, 4 SUB, 5 SHL, 6 SHR, 7 JUMP, 8 JGE, 9 LDF, 10 STF, 11 JZX, 12 LDX, 13 STX, 14 INCX, 15 no operation.
- R3: LOAD copies the word at the effective address into AC. STORE writes AC to that address.
- R4: ADD and SUB add or subtract the word at the effective address to or from AC, in 16-bit two's complement, wrapping on overflow.
- R5: SHL doubles AC by shifting it left one place and inserting a zero. SHR halves AC arithmetically and keeps the sign bit. Neither reads memory.
- R6: JUMP loads PC with the effective address. JGE does the same only when AC bit 15 is 0, that is, when AC is zero or positive.
- R7: LDF sets AC to the 11-bit address field of the addressed word, zero-extended. STF replaces bits 10:0 of the addressed word with AC bits 10:0 and keeps bits 15:11.
- R8: JZX jumps to the effective address when IX is zero. Otherwise it increments IX and falls through.
- R9: LDX loads IX with the low 11 bits of the addressed word. STX stores IX sign-extended to 16 bits. INCX adds the address field to IX modulo 2048, so a field of 0x7FB subtracts 5.
- R10: An instruction that reads an operand takes 4 cycles; any other instruction takes 3. A write to an instruction word takes effect at that word's next fetch, even when that fetch is in the cycle right after the write.
- R11: After HALT, `halted` stays high, PC, AC and IX hold their values, and no memory access is made until reset. Opcode 15 changes nothing and moves on to the next instruction.
- R12: The memory port never requests a read and a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 11 | Word address of the memory access |
| mem_rd | output | 1 | Read request; data returns one cycle later |
| mem_we | output | 1 | Write request for mem_wdata at mem_addr |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_rd |
| halted | output | 1 | High once a HALT has executed |
| dbg_pc | output | 11 | Program counter |
| dbg_ac | output | 16 | Accumulator |
| dbg_ix | output | 11 | Index register |

## Verification
The two functions that can meet in the same cycle are an address-field write and the instruction fetch that follows it. A STF whose target is the next instruction word writes that word in its execute cycle, and the fetch of the same word comes at the very next clock edge. The bench runs a program that patches the LOAD right after the STF and then checks two things: the accumulator must hold the value from the patched address, and the opcode bits of the patched word must be unchanged. A second overlap sits in JZX, which increments the index and falls through in the same step. The indexed loop also wraps its effective address below the base, and the bench judges both through the array results it writes.

// File: rtl/accum_cpu_pkg.sv
package accum_cpu_pkg;

    localparam int OPC_W  = 4;
    localparam int ADDR_W = 11;
    localparam int WORD_W = OPC_W + 1 + ADDR_W;
    localparam int IX_W   = ADDR_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IX_W-1:0]   ix_t;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT  = 4'd0,
        OP_LOAD  = 4'd1,
        OP_STORE = 4'd2,
        OP_ADD   = 4'd3,
        OP_SUB   = 4'd4,
        OP_SHL   = 4'd5,
        OP_SHR   = 4'd6,
        OP_JMP   = 4'd7,
        OP_JGE   = 4'd8,
        OP_LDF   = 4'd9,
        OP_STF   = 4'd10,
        OP_JZX   = 4'd11,
        OP_LDX   = 4'd12,
        OP_STX   = 4'd13,
        OP_INCX  = 4'd14,
        OP_NOP   = 4'd15
    } opcode_e;

    typedef struct packed {
        opcode_e op;
        logic    idx;
        addr_t   addr;
    } instr_t;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_OPER, ST_EXEC, ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        AC_HOLD, AC_MEM, AC_ADD, AC_SUB, AC_SHL, AC_SHR, AC_FIELD
    } ac_op_e;

    typedef enum logic [1:0] {
        IX_HOLD, IX_LOAD, IX_INC_NZ, IX_ADDK
    } ix_op_e;

    typedef enum logic [1:0] {
        WR_NONE, WR_AC, WR_IX, WR_FIELD
    } wr_kind_e;

    typedef enum logic [1:0] {
        BR_NONE, BR_ALWAYS, BR_NONNEG, BR_IXZERO
    } br_kind_e;

    typedef struct packed {
        logic     halt;
        logic     needs_read;
        ac_op_e   ac_op;
        ix_op_e   ix_op;
        wr_kind_e wr_kind;
        br_kind_e br_kind;
    } ctrl_t;

    function automatic word_t widen_ix(ix_t v);
        return {{(WORD_W-IX_W){v[IX_W-1]}}, v};
    endfunction

    function automatic word_t merge_field(word_t old_w, addr_t f);
        return {old_w[WORD_W-1:ADDR_W], f};
    endfunction

endpackage

// File: rtl/accum_cpu_decode.sv
module accum_cpu_decode
    import accum_cpu_pkg::*;
(
    input  opcode_e op,
    output ctrl_t   ctrl
);

    always_comb begin
        ctrl.halt       = 1'b0;
        ctrl.needs_read = 1'b0;
        ctrl.ac_op      = AC_HOLD;
        ctrl.ix_op      = IX_HOLD;
        ctrl.wr_kind    = WR_NONE;
        ctrl.br_kind    = BR_NONE;
        case (op)
            OP_HALT:  ctrl.halt = 1'b1;
            OP_LOAD:  begin ctrl.needs_read = 1'b1; ctrl.ac_op = AC_MEM;   end
            OP_STORE: ctrl.wr_kind = WR_AC;
            OP_ADD:   begin ctrl.needs_read = 1'b1; ctrl.ac_op = AC_ADD;   end
            OP_SUB:   begin ctrl.needs_read = 1'b1; ctrl.ac_op = AC_SUB;   end
            OP_SHL:   ctrl.ac_op = AC_SHL;
            OP_SHR:   ctrl.ac_op = AC_SHR;
            OP_JMP:   ctrl.br_kind = BR_ALWAYS;
            OP_JGE:   ctrl.br_kind = BR_NONNEG;
            OP_LDF:   begin ctrl.needs_read = 1'b1; ctrl.ac_op = AC_FIELD; end
            OP_STF:   begin ctrl.needs_read = 1'b1; ctrl.wr_kind = WR_FIELD; end
            OP_JZX:   begin ctrl.br_kind = BR_IXZERO; ctrl.ix_op = IX_INC_NZ; end
            OP_LDX:   begin ctrl.needs_read = 1'b1; ctrl.ix_op = IX_LOAD;  end
            OP_STX:   ctrl.wr_kind = WR_IX;
            OP_INCX:  ctrl.ix_op = IX_ADDK;
            default:  ;
        endcase
    end

endmodule

// File: rtl/accum_cpu_alu.sv
module accum_cpu_alu
    import accum_cpu_pkg::*;
(
    input  ac_op_e ac_op,
    input  word_t  ac,
    input  word_t  operand,
    output word_t  result
);

    always_comb begin
        case (ac_op)
            AC_MEM:   result = operand;
            AC_ADD:   result = ac + operand;
            AC_SUB:   result = ac - operand;
            AC_SHL:   result = {ac[WORD_W-2:0], 1'b0};
            AC_SHR:   result = {ac[WORD_W-1], ac[WORD_W-1:1]};
            AC_FIELD: result = {{(WORD_W-ADDR_W){1'b0}}, operand[ADDR_W-1:0]};
            default:  result = ac;
        endcase
    end

endmodule

// File: rtl/accum_cpu_index.sv
module accum_cpu_index
    import accum_cpu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  ix_op_e ix_op,
    input  word_t  load_word,
    input  addr_t  step,
    output ix_t    ix,
    output logic   ix_zero
);

    assign ix_zero = (ix == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ix <= '0;
        end else if (en) begin
            case (ix_op)
                IX_LOAD:   ix <= load_word[IX_W-1:0];
                IX_INC_NZ: if (!ix_zero) ix <= ix + 1'b1;
                IX_ADDK:   ix <= ix + step;
                default:   ;
            endcase
        end
    end

    // R8: a test-and-step on a nonzero index advances it by one
    a_r8_step_nonzero: assert property (@(posedge clk) disable iff (rst)
        (en && ix_op == IX_INC_NZ && ix != '0) |=> (ix == $past(ix) + 1'b1));

    // R8: a test-and-step on a zero index leaves it at zero
    a_r8_hold_zero: assert property (@(posedge clk) disable iff (rst)
        (en && ix_op == IX_INC_NZ && ix == '0) |=> (ix == '0));

endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
    import accum_cpu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_rd,
    output logic                mem_we,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                halted,
    output logic [ADDR_W-1:0]   dbg_pc,
    output logic [WORD_W-1:0]   dbg_ac,
    output logic [IX_W-1:0]     dbg_ix
);

    state_e state;
    addr_t  pc;
    word_t  ac;
    instr_t ir;
    ix_t    ix;
    logic   ix_zero;
    ctrl_t  ctrl;
    word_t  alu_res;
    addr_t  ea;
    logic   stage_go;
    logic   ac_en;
    logic   take_branch;

    accum_cpu_decode u_decode (
        .op   (ir.op),
        .ctrl (ctrl)
    );

    accum_cpu_alu u_alu (
        .ac_op   (ctrl.ac_op),
        .ac      (ac),
        .operand (mem_rdata),
        .result  (alu_res)
    );

    accum_cpu_index u_index (
        .clk       (clk),
        .rst       (rst),
        .en        (stage_go),
        .ix_op     (ctrl.ix_op),
        .load_word (mem_rdata),
        .step      (ir.addr),
        .ix        (ix),
        .ix_zero   (ix_zero)
    );

    // Effective address wraps inside the address space
    assign ea = ir.idx ? (ir.addr + ix) : ir.addr;

    // Completion stage: the operand cycle for register-only ops, execute otherwise
    assign stage_go = ((state == ST_OPER) && !ctrl.needs_read && !ctrl.halt) ||
                      ((state == ST_EXEC) &&  ctrl.needs_read);
    assign ac_en    = stage_go && (ctrl.ac_op != AC_HOLD);

    always_comb begin
        case (ctrl.br_kind)
            BR_ALWAYS: take_branch = 1'b1;
            BR_NONNEG: take_branch = !ac[WORD_W-1];
            BR_IXZERO: take_branch = ix_zero;
            default:   take_branch = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
            pc    <= '0;
            ac    <= '0;
            ir    <= '0;
        end else begin
            if (ac_en) ac <= alu_res;
            case (state)
                ST_FETCH:  state <= ST_DECODE;
                ST_DECODE: begin
                    ir    <= instr_t'(mem_rdata);
                    pc    <= pc + 1'b1;
                    state <= ST_OPER;
                end
                ST_OPER: begin
                    if (ctrl.halt)            state <= ST_HALT;
                    else if (ctrl.needs_read) state <= ST_EXEC;
                    else                      state <= ST_FETCH;
                    if (take_branch) pc <= ea;
                end
                ST_EXEC:   state <= ST_FETCH;
                default:   state <= ST_HALT;
            endcase
        end
    end

    always_comb begin
        mem_rd    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ea;
        mem_wdata = '0;
        case (state)
            ST_FETCH: begin
                mem_rd   = 1'b1;
                mem_addr = pc;
            end
            ST_OPER: begin
                mem_rd = ctrl.needs_read && !ctrl.halt;
                if (ctrl.wr_kind == WR_AC) begin
                    mem_we    = 1'b1;
                    mem_wdata = ac;
                end else if (ctrl.wr_kind == WR_IX) begin
                    mem_we    = 1'b1;
                    mem_wdata = widen_ix(ix);
                end
            end
            ST_EXEC: begin
                if (ctrl.wr_kind == WR_FIELD) begin
                    mem_we    = 1'b1;
                    mem_wdata = merge_field(mem_rdata, ac[ADDR_W-1:0]);
                end
            end
            default: ;
        endcase
    end

    assign halted = (state == ST_HALT);
    assign dbg_pc = pc;
    assign dbg_ac = ac;
    assign dbg_ix = ix;

    // R12: read and write requests are exclusive
    a_r12_rd_we_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_we));

    // R11: a halted processor stays halted and keeps its registers
    a_r11_halt_holds: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc) && $stable(ac) && $stable(ix)));

    // R11: a halted processor makes no memory access
    a_r11_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_we));

    // R10: every decode steps the program counter by one
    a_r10_pc_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE) |=> (pc == $past(pc) + 1'b1));

    // R5: a left shift doubles the accumulator
    a_r5_shl_doubles: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OPER && ir.op == OP_SHL) |=> (ac == {$past(ac[WORD_W-2:0]), 1'b0}));

    // R1: the first cycle after reset is a fetch from address zero
    a_r1_start_fetch: assert property (@(posedge clk)
        $past(rst) && !rst |-> (mem_rd && mem_addr == '0 && !halted));

endmodule

// File: tb/accum_cpu_bench.sv
module accum_cpu_bench;
    import accum_cpu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    // {opcode, first operand, second operand, expected AC}
    localparam logic [51:0] VEC [NVEC] = '{
        {4'd1,  16'h1234, 16'hABCD, 16'hABCD},
        {4'd3,  16'h7FFF, 16'h0001, 16'h8000},
        {4'd3,  16'hFFFF, 16'h0003, 16'h0002},
        {4'd4,  16'h0005, 16'h0007, 16'hFFFE},
        {4'd5,  16'hC001, 16'h0000, 16'h8002},
        {4'd6,  16'h8004, 16'h0000, 16'hC002},
        {4'd6,  16'h0009, 16'h0000, 16'h0004},
        {4'd9,  16'h0000, 16'hF9AB, 16'h01AB},
        {4'd15, 16'h5555, 16'h1111, 16'h5555},
        {4'd5,  16'h4000, 16'h0000, 16'h8000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] mem_addr;
    logic        mem_rd;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        halted;
    logic [10:0] dbg_pc;
    logic [15:0] dbg_ac;
    logic [10:0] dbg_ix;

    logic [15:0] mem [0:2047];
    int checks = 0;
    int errors = 0;
    int halt_access = 0;
    int both_access = 0;
    bit done = 1'b0;

    accum_cpu u_accum_cpu (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted), .dbg_pc(dbg_pc), .dbg_ac(dbg_ac), .dbg_ix(dbg_ix)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    always @(negedge clk) begin
        if (!rst && halted && (mem_rd || mem_we)) halt_access++;
        if (!rst && mem_rd && mem_we) both_access++;
    end

    function automatic logic [15:0] enc(opcode_e op, logic idx, logic [10:0] a);
        return {4'(op), idx, a};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic run(output int cyc);
        cyc = 0;
        while (!halted && cyc < 3000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        if (!halted) check("R11 halt reached", 32'd0, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cyc;
        logic [10:0] pc_h;
        logic [15:0] ac_h;
        logic [10:0] ix_h;

        // Table of two-operand programs: LOAD 100; <op> 101; HALT
        for (int v = 0; v < NVEC; v++) begin
            clear_mem();
            mem[0]   = enc(OP_LOAD, 1'b0, 11'd100);
            mem[1]   = {VEC[v][51:48], 1'b0, 11'd101};
            mem[2]   = enc(OP_HALT, 1'b0, 11'd0);
            mem[100] = VEC[v][47:32];
            mem[101] = VEC[v][31:16];
            do_reset();
            run(cyc);
            check($sformatf("R3/R4/R5/R7/R11 vector %0d", v), dbg_ac, VEC[v][15:0]);
        end

        // R1: reset clears the registers left by the last vector
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 pc", dbg_pc, 0);
        check("R1 ac", dbg_ac, 0);
        check("R1 ix", dbg_ix, 0);
        check("R1 halted", halted, 0);

        // R10: cycle counts (LOAD 4 + HALT 3; SHL 3 + HALT 3)
        clear_mem();
        mem[0] = enc(OP_LOAD, 1'b0, 11'd100);
        mem[1] = enc(OP_HALT, 1'b0, 11'd0);
        do_reset();
        run(cyc);
        check("R10 read op cycles", cyc, 7);
        clear_mem();
        mem[0] = enc(OP_SHL, 1'b0, 11'd0);
        mem[1] = enc(OP_HALT, 1'b0, 11'd0);
        do_reset();
        run(cyc);
        check("R10 register op cycles", cyc, 6);

        // R3 store, then R11 hold while halted
        clear_mem();
        mem[0]   = enc(OP_LOAD, 1'b0, 11'd100);
        mem[1]   = enc(OP_STORE, 1'b0, 11'd105);
        mem[2]   = enc(OP_HALT, 1'b0, 11'd0);
        mem[100] = 16'h4321;
        do_reset();
        run(cyc);
        check("R3 store", mem[105], 16'h4321);
        pc_h = dbg_pc; ac_h = dbg_ac; ix_h = dbg_ix;
        repeat (10) @(negedge clk);
        check("R11 halted stays", halted, 1);
        check("R11 pc held", dbg_pc, pc_h);
        check("R11 ac held", dbg_ac, ac_h);
        check("R11 ix held", dbg_ix, ix_h);

        // R6: sign branch and jump
        for (int k = 0; k < 3; k++) begin
            clear_mem();
            mem[0]   = enc(OP_LOAD, 1'b0, 11'd100);
            mem[1]   = enc(OP_JGE, 1'b0, 11'd4);
            mem[2]   = enc(OP_LOAD, 1'b0, 11'd101);
            mem[3]   = enc(OP_HALT, 1'b0, 11'd0);
            mem[4]   = enc(OP_LOAD, 1'b0, 11'd102);
            mem[5]   = enc(OP_JMP, 1'b0, 11'd3);
            mem[100] = (k == 0) ? 16'h8000 : (k == 1) ? 16'h0000 : 16'h7FFF;
            mem[101] = 16'hAAAA;
            mem[102] = 16'hBBBB;
            do_reset();
            run(cyc);
            check($sformatf("R6 branch case %0d", k), dbg_ac, (k == 0) ? 16'hAAAA : 16'hBBBB);
        end

        // R2/R8/R9: indexed loop C[i] = A[i] + B[i] over three elements
        clear_mem();
        mem[0] = enc(OP_LDX, 1'b0, 11'd50);
        mem[1] = enc(OP_JZX, 1'b0, 11'd7);
        mem[2] = enc(OP_LOAD, 1'b1, 11'd202);
        mem[3] = enc(OP_ADD, 1'b1, 11'd212);
        mem[4] = enc(OP_STORE, 1'b1, 11'd222);
        mem[5] = enc(OP_JMP, 1'b0, 11'd1);
        mem[7] = enc(OP_INCX, 1'b0, 11'h7FB);
        mem[8] = enc(OP_STX, 1'b0, 11'd51);
        mem[9] = enc(OP_HALT, 1'b0, 11'd0);
        mem[50] = 16'hF7FD;
        mem[200] = 16'd10; mem[201] = 16'd20; mem[202] = 16'd30;
        mem[210] = 16'd1;  mem[211] = 16'd2;  mem[212] = 16'd3;
        do_reset();
        run(cyc);
        check("R2/R8 element 0", mem[220], 16'd11);
        check("R2/R8 element 1", mem[221], 16'd22);
        check("R2/R8 element 2", mem[222], 16'd33);
        check("R9 index after add", dbg_ix, 11'h7FB);
        check("R9 index widened", mem[51], 16'hFFFB);

        // R7/R10: patch the next instruction's address field, then run it
        clear_mem();
        mem[0]   = enc(OP_LDF, 1'b0, 11'd3);
        mem[1]   = enc(OP_ADD, 1'b0, 11'd20);
        mem[2]   = enc(OP_STF, 1'b0, 11'd3);
        mem[3]   = enc(OP_LOAD, 1'b0, 11'd100);
        mem[4]   = enc(OP_HALT, 1'b0, 11'd0);
        mem[20]  = 16'd1;
        mem[100] = 16'h1111;
        mem[101] = 16'h2222;
        do_reset();
        run(cyc);
        check("R7/R10 patched load", dbg_ac, 16'h2222);
        check("R7 opcode kept", mem[3], enc(OP_LOAD, 1'b0, 11'd101));

        check("R11 no access while halted", halt_access, 0);
        check("R12 no read with write", both_access, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule